// File: doc/BRIEF.md
# Interleaved video scan address generator

This block produces the memory address of every byte a raster display fetches from a frame buffer that is laid out in interleaved order. Two free-running counters step through the frame: a column counter of 65 fetch slots per scan line and a line counter of 262 lines. From their values the block forms one 16-bit byte address per clock. In character/low-resolution mode each of the 24 character rows covers eight scan lines. In bitmap mode each of the 192 scan lines has its own 40-byte line.

Rows are not stored one after another. Three 40-byte rows share a 128-byte block, followed by 8 unused bytes. Display rows 0, 8 and 16 sit back to back within a block, and consecutive rows inside a group of eight are 0x80 apart. Bitmap mode adds a 0x400 stride for the scan line within a character row.

Fetches continue through horizontal and vertical blanking, so the display keeps refreshing the DRAM. The block also outputs a 7-bit refresh row, taken from address bits that do not depend on the mode. That row runs through all 128 values in every frame, whichever mode is selected. The mode and page inputs are registered at the start of each fetch, so the address never changes in the middle of a fetch.

Top module: `vscan_addr`

## Requirements
- R1: While reset (rst_n low, asynchronous) is held, and directly after it: h_cnt = 0, v_cnt = 0, active = 1, addr = 0x0400, refresh_row = 0, and the registered mode and page are both 0.
- R2: Every clock, h_cnt advances by one, from 0 to 64 and then back to 0. When h_cnt goes from 64 to 0, v_cnt advances by one, from 0 to 261 and then back to 0.
- R3: active is 1 exactly when h_cnt < 40 and v_cnt < 192.
- R4: Define low = (0x80·((v_cnt div 8) mod 8) + 0x28·(v_cnt div 64) + h_cnt) mod 1024. This definition holds in blanking as well.
- R5: In character mode, addr = 0x0400 + low when the page is 0, and 0x0800 + low when the page is 1. Over the active region this equals 0x0400 + 0x80·(row mod 8) + 0x28·(row div 8) + column, with row = v_cnt div 8.
- R6: In bitmap mode, addr = 0x2000 (page 0) or 0x4000 (page 1), plus 0x400·(v_cnt mod 8), plus low.
- R7: Whenever active = 1, addr mod 128 < 0x78. The 8 padding bytes of a 128-byte block are never fetched during active display.
- R8: refresh_row (bit 6 down to bit 0) = {bit 2 of v_cnt, addr[8], addr[7], addr[3:0]}. In bitmap mode bit 6 equals addr[12]. The refresh row never depends on the mode or the page.
- R9: Starting from v_cnt = 0, h_cnt = 0, every one of the 128 refresh_row values appears at least once in each 17030-cycle frame, in either mode.
- R10: The values of mode_hires (1 = bitmap, 0 = character) and page_sel present at a rising clock edge control addr from that edge until the next one. A change between edges has no effect until the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fetch clock, one byte fetch per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_hires | input | 1 | 1 = bitmap mode, 0 = character/low-resolution mode |
| page_sel | input | 1 | Selects the second display page |
| h_cnt | output | 7 | Column counter, 0 to 64 |
| v_cnt | output | 9 | Line counter, 0 to 261 |
| active | output | 1 | Current fetch lies in the visible area |
| addr | output | 16 | Byte address of the current fetch |
| refresh_row | output | 7 | DRAM row address carried by the current fetch |

## Verification
The hardest condition to reach from the ports is a mode or page change on an arbitrary cycle, including one in the middle of a scan line. Under those changes the refresh row must follow its mode-free sequence while the address jumps between the two buffers. The stimulus runs two whole frames with the mode fixed, one per mode, and collects all 128 refresh values in each. It then runs a frame in which mode and page are redrawn from $urandom on every cycle, and another in which they change once per line. Every cycle's address and refresh row are compared with closed-form values, including those in blanking.

// File: rtl/vscan_addr.sv
module vscan_addr #(
  parameter int H_TOTAL  = 65,
  parameter int H_ACTIVE = 40,
  parameter int V_TOTAL  = 262,
  parameter int V_ACTIVE = 192,
  localparam int HW = $clog2(H_TOTAL),
  localparam int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_hires,
  input  logic          page_sel,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          active,
  output logic [15:0]   addr,
  output logic [6:0]    refresh_row
);
  localparam logic [9:0]  ROW_STEP   = 10'h080;
  localparam logic [9:0]  THIRD_STEP = 10'h028;
  localparam logic [15:0] TXT_BASE   = 16'h0400;
  localparam logic [15:0] BMP_BASE   = 16'h2000;

  logic mode_q, page_q;
  logic h_last, v_last;

  assign h_last = (h_cnt == HW'(H_TOTAL - 1));
  assign v_last = (v_cnt == VW'(V_TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt  <= '0;
      v_cnt  <= '0;
      mode_q <= 1'b0;
      page_q <= 1'b0;
    end else begin
      mode_q <= mode_hires;
      page_q <= page_sel;
      h_cnt  <= h_last ? '0 : h_cnt + 1'b1;
      if (h_last) v_cnt <= v_last ? '0 : v_cnt + 1'b1;
    end
  end

  logic [2:0]  grp_row;
  logic [2:0]  third;
  logic [2:0]  sub_line;
  logic [9:0]  low;
  logic [15:0] hi;

  assign sub_line = v_cnt[2:0];
  assign grp_row  = v_cnt[5:3];
  assign third    = 3'(v_cnt[VW-1:6]);
  assign low      = ROW_STEP * 10'(grp_row) + THIRD_STEP * 10'(third) + 10'(h_cnt);

  assign hi = mode_q ? ((page_q ? BMP_BASE << 1 : BMP_BASE) | {3'b000, sub_line, 10'b0})
                     : (page_q ? TXT_BASE << 1 : TXT_BASE);

  assign addr        = hi | {6'b0, low};
  assign refresh_row = {sub_line[2], low[8:7], low[3:0]};
  assign active      = (h_cnt < HW'(H_ACTIVE)) && (v_cnt < VW'(V_ACTIVE));
endmodule

module vscan_addr_chk #(
  parameter int H_TOTAL = 65,
  parameter int V_TOTAL = 262,
  parameter int HW = 7,
  parameter int VW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_hires,
  input logic          page_sel,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt,
  input logic          active,
  input logic [15:0]   addr,
  input logic [6:0]    refresh_row
);
  // R2
  h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == HW'(H_TOTAL - 1)) |=> (h_cnt == '0));
  // R2
  h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != HW'(H_TOTAL - 1)) |=> (h_cnt == $past(h_cnt) + 1'b1) && $stable(v_cnt));
  // R2
  v_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == HW'(H_TOTAL - 1) && v_cnt == VW'(V_TOTAL - 1)) |=> (v_cnt == '0));
  // R7
  no_padding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (addr[6:0] < 7'h78));
  // R10
  mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(mode_hires) ? (addr >= 16'h2000) : (addr < 16'h0C00)));
  // R8
  row_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_row[5:0] == {addr[8:7], addr[3:0]}));
  // R8
  row_a12_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_hires) |-> (refresh_row[6] == addr[12]));
endmodule

bind vscan_addr vscan_addr_chk #(.H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW)) u_chk (.*);

// File: tb/tb_vscan_addr.sv
`timescale 1ns/1ps
module tb_vscan_addr;
  localparam int HT = 65, VT = 262, FRAME = HT * VT;

  logic clk = 1'b0, rst_n = 1'b0, mode_hires = 1'b0, page_sel = 1'b0;
  logic [6:0] h_cnt;
  logic [8:0] v_cnt;
  logic active;
  logic [15:0] addr;
  logic [6:0] refresh_row;

  int checks = 0, errors = 0;
  bit done = 0;
  int eh, ev, em, ep;
  logic [127:0] seen;

  always #4 clk = ~clk;

  vscan_addr dut (.clk(clk), .rst_n(rst_n), .mode_hires(mode_hires), .page_sel(page_sel),
                  .h_cnt(h_cnt), .v_cnt(v_cnt), .active(active), .addr(addr),
                  .refresh_row(refresh_row));

  function automatic int low_of(int h, int v);
    return (128 * ((v / 8) % 8) + 40 * (v / 64) + h) % 1024;
  endfunction

  function automatic int addr_of(int h, int v, int m, int p);
    if (m != 0) return (p != 0 ? 16384 : 8192) + 1024 * (v % 8) + low_of(h, v);
    return (p != 0 ? 2048 : 1024) + low_of(h, v);
  endfunction

  function automatic int row_of(int h, int v);
    int l = low_of(h, v);
    return ((v / 4) % 2) * 64 + ((l / 128) % 4) * 16 + (l % 16);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (h=%0d v=%0d)", req, act, exp, eh, ev);
    end
  endtask

  task automatic check_cycle();
    int ea = addr_of(eh, ev, em, ep);
    check("R2 h_cnt", int'(h_cnt), eh);
    check("R2 v_cnt", int'(v_cnt), ev);
    check("R3 active", int'(active), (eh < 40 && ev < 192) ? 1 : 0);
    check(em != 0 ? "R6 bitmap addr" : "R5 R4 char addr", int'(addr), ea);
    check("R8 refresh_row", int'(refresh_row), row_of(eh, ev));
    if (eh < 40 && ev < 192) check("R7 padding", (ea % 128) < 120 ? 1 : 0, 1);
    seen[refresh_row] = 1'b1;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    em = int'(mode_hires);
    ep = int'(page_sel);
    if (eh == HT - 1) begin
      eh = 0;
      ev = (ev == VT - 1) ? 0 : ev + 1;
    end else eh++;
    @(negedge clk);
  endtask

  task automatic run_frame(int kind);
    seen = '0;
    for (int c = 0; c < FRAME; c++) begin
      check_cycle();
      case (kind)
        0: begin mode_hires = 1'b0; page_sel = 1'b0; end
        1: begin mode_hires = 1'b1; page_sel = 1'b0; end
        2: begin mode_hires = 1'($urandom); page_sel = 1'($urandom); end
        default: if (eh == HT - 1) begin mode_hires = 1'($urandom); page_sel = 1'($urandom); end
      endcase
      step();
    end
    if (kind < 2) check(kind == 0 ? "R9 char coverage" : "R9 bitmap coverage", $countones(seen), 128);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    eh = 0; ev = 0; em = 0; ep = 0;
    mode_hires = 1'b1; page_sel = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 h_cnt", int'(h_cnt), 0);
    check("R1 v_cnt", int'(v_cnt), 0);
    check("R1 addr", int'(addr), 16'h0400);
    check("R1 active", int'(active), 1);
    check("R1 refresh_row", int'(refresh_row), 0);
    mode_hires = 1'b0; page_sel = 1'b0;
    rst_n = 1'b1;
    check_cycle();
    step();
    // R10: input changes between edges take effect only at the next edge
    mode_hires = 1'b1;
    #1 check("R10 no mid-cycle effect", int'(addr), addr_of(eh, ev, em, ep));
    mode_hires = 1'b0;
    for (int c = 1; c < FRAME; c++) begin
      check_cycle();
      step();
    end
    run_frame(1);
    run_frame(0);
    run_frame(2);
    run_frame(3);
    // R5 R6: boundary rows with the second page
    mode_hires = 1'b1; page_sel = 1'b1;
    step();
    check_cycle();
    check("R10 latched after edge", int'(addr), addr_of(eh, ev, 1, 1));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule